// File: doc/BRIEF.md
# Dual Signed Halfword Multiply-Accumulate Unit

This datapath unit serves the execute stage of a 32-bit processor. Each accepted operation splits two source words into signed halfwords and forms two 16x16 products. Both products are added to a 64-bit accumulator, which the caller presents as a high word and a low word. The 64-bit sum comes back in the same split form. A mode bit can exchange the two halfwords of the second source before the multiply. That yields cross products, top times bottom and bottom times top, in place of matching ones.

The unit also receives the four 4-bit register indices of the operation: two destinations and two sources. It reports encodings that are not legal. If the two destinations coincide, a policy input decides the outcome: trap as an undefined instruction, drop the write, or write a value that is not specified. Every operation takes exactly two cycles from in_valid to out_valid, whatever the operand values.

Top module: `dual_mac_unit`

## Requirements
- R1: With swap low, the result is the sign-extended sum of two products added to the accumulator. One product is op_a[15:0] times op_b[15:0], the other op_a[31:16] times op_b[31:16], and every halfword is read as signed two's complement.
- R2: With swap high, op_b is rotated by 16 bits before the multiply. The products are then op_a[15:0] times op_b[31:16] and op_a[31:16] times op_b[15:0].
- R3: The 64-bit addition wraps modulo 2^64. Overflow sets no flag, and a legal operation still writes with undef_flag low.
- R4: The accumulator is {acc_hi, acc_lo}, read as signed. Result bits 63:32 appear on res_hi and bits 31:0 on res_lo.
- R5: If any of idx_dlo, idx_dhi, idx_a or idx_b equals 15, unpred_flag is set. That condition alone leaves wr_en high and undef_flag low.
- R6: If idx_dhi equals idx_dlo, unpred_flag is set, and the policy input picks the resolution. Policy 0 (and the unused code 3) sets undef_flag with wr_en low. Policy 1 gives wr_en low with undef_flag low. Policy 2 gives wr_en high with undef_flag low.
- R7: out_valid rises exactly two clock cycles after in_valid is sampled high, for every operand value, and it is low two cycles after in_valid is sampled low.
- R8: After a synchronous active-high reset, out_valid, wr_en, undef_flag, unpred_flag, res_hi and res_lo are all zero.
- R9: While out_valid is low, wr_en, undef_flag and unpred_flag are low.
- R10: Let both halfword pairs be -32768 times -32768 and the accumulator zero. The result is then +2^31: res_hi = 0x00000000 and res_lo = 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op_a | input | 32 | First source word |
| op_b | input | 32 | Second source word |
| acc_hi | input | 32 | Accumulator bits 63:32 |
| acc_lo | input | 32 | Accumulator bits 31:0 |
| swap | input | 1 | Exchange the halfwords of op_b before multiplying |
| idx_dlo | input | 4 | Register index of the low destination |
| idx_dhi | input | 4 | Register index of the high destination |
| idx_a | input | 4 | Register index of the first source |
| idx_b | input | 4 | Register index of the second source |
| clash_policy | input | 2 | Resolution of equal destinations: 0 trap, 1 skip, 2 write |
| out_valid | output | 1 | Result present on the outputs |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |
| wr_en | output | 1 | Destination write permitted |
| undef_flag | output | 1 | Operation traps as undefined |
| unpred_flag | output | 1 | Index combination is not legal |

## Verification
The bench builds the unit with its default parameters: 16-bit halfwords, 4-bit indices and reserved index 15. These defaults reach the full signed range of each halfword, the single +2^30 product and its doubling to +2^31, and every index value, including the reserved one. A behavioural model queues a 64-bit integer result for each cycle and compares it two cycles later. The stimulus covers back-to-back and gapped valid patterns, accumulators near both signed limits that force wraparound, and each clash policy code.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    CLASH_TRAP  = 2'd0,
    CLASH_SKIP  = 2'd1,
    CLASH_STORE = 2'd2,
    CLASH_RSVD  = 2'd3
  } clash_pol_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/dmac_operand_route.sv
module dmac_operand_route #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              swap,
  input  logic [WORD_W-1:0] b_in,
  output logic [WORD_W-1:0] b_out
);
  logic [WORD_W-1:0] rotated;

  assign rotated = (b_in >> HALF_W) | (b_in << (WORD_W - HALF_W));
  assign b_out   = swap ? rotated : b_in;
endmodule

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HALF_W-1:0] a_h,
  input  logic [HALF_W-1:0] b_h,
  output logic [PROD_W-1:0] prod
);
  localparam logic [HALF_W-1:0] MIN_H    = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] MAX_PROD = {2'b01, {(PROD_W-2){1'b0}}};

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;

  assign a_ext = PROD_W'($signed(a_h));
  assign b_ext = PROD_W'($signed(b_h));

  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
    end else if (en) begin
      prod <= a_ext * b_ext;
    end
  end

  // R10: the most negative pair must give the single positive maximum
  assert_corner_product_R10: assert property (@(posedge clk) disable iff (rst)
    (en && a_h == MIN_H && b_h == MIN_H) |=> (prod == MAX_PROD));
endmodule

// File: rtl/dmac_idx_check.sv
module dmac_idx_check #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned RESV_IDX = 15
) (
  input  logic [IDX_W-1:0] idx_dlo,
  input  logic [IDX_W-1:0] idx_dhi,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic             uses_resv,
  output logic             dest_clash
);
  localparam logic [IDX_W-1:0] RESV = IDX_W'(RESV_IDX);

  assign uses_resv  = (idx_dlo == RESV) || (idx_dhi == RESV) ||
                      (idx_a == RESV)   || (idx_b == RESV);
  assign dest_clash = (idx_dhi == idx_dlo);
endmodule

// File: rtl/dmac_accum.sv
module dmac_accum #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned PROD_W = 32,
  parameter int unsigned ACC_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [LANES*PROD_W-1:0] prods,
  input  logic [ACC_W-1:0]        acc,
  output logic [ACC_W-1:0]        sum
);
  localparam int unsigned EXT_W = ACC_W - PROD_W;

  logic [ACC_W-1:0] sum_next;

  always_comb begin
    sum_next = acc;
    for (int i = 0; i < int'(LANES); i++) begin
      sum_next = sum_next + {{EXT_W{prods[i*PROD_W + PROD_W-1]}},
                             prods[i*PROD_W +: PROD_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum <= '0;
    end else if (en) begin
      sum <= sum_next;
    end
  end
endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit #(
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned RESV_IDX = 15,
  localparam int unsigned WORD_W  = 2 * HALF_W,
  localparam int unsigned PROD_W  = 2 * HALF_W,
  localparam int unsigned ACC_W   = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] acc_hi,
  input  logic [WORD_W-1:0] acc_lo,
  input  logic              swap,
  input  logic [IDX_W-1:0]  idx_dlo,
  input  logic [IDX_W-1:0]  idx_dhi,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [1:0]        clash_policy,
  output logic              out_valid,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic              wr_en,
  output logic              undef_flag,
  output logic              unpred_flag
);
  import dmac_pkg::*;

  logic [WORD_W-1:0]       b_sel;
  logic [LANES*PROD_W-1:0] prods;
  logic                    uses_resv;
  logic                    dest_clash;

  // stage 1 state
  logic              s1_valid;
  logic [ACC_W-1:0]  s1_acc;
  logic              s1_resv;
  logic              s1_clash;
  clash_pol_e        s1_pol;

  // stage 2 result
  logic [ACC_W-1:0]  s2_sum;

  dmac_operand_route #(.HALF_W(HALF_W)) i_route (
    .swap  (swap),
    .b_in  (op_b),
    .b_out (b_sel)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    dmac_lane_mul #(.HALF_W(HALF_W)) i_mul (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .a_h  (op_a[g*HALF_W +: HALF_W]),
      .b_h  (b_sel[g*HALF_W +: HALF_W]),
      .prod (prods[g*PROD_W +: PROD_W])
    );
  end

  dmac_idx_check #(.IDX_W(IDX_W), .RESV_IDX(RESV_IDX)) i_idx (
    .idx_dlo    (idx_dlo),
    .idx_dhi    (idx_dhi),
    .idx_a      (idx_a),
    .idx_b      (idx_b),
    .uses_resv  (uses_resv),
    .dest_clash (dest_clash)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_acc   <= '0;
      s1_resv  <= 1'b0;
      s1_clash <= 1'b0;
      s1_pol   <= CLASH_TRAP;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_acc   <= {acc_hi, acc_lo};
        s1_resv  <= uses_resv;
        s1_clash <= dest_clash;
        s1_pol   <= clash_pol_e'(clash_policy);
      end
    end
  end

  dmac_accum #(.LANES(LANES), .PROD_W(PROD_W), .ACC_W(ACC_W)) i_acc (
    .clk   (clk),
    .rst   (rst),
    .en    (s1_valid),
    .prods (prods),
    .acc   (s1_acc),
    .sum   (s2_sum)
  );

  logic trap_now;
  logic block_now;

  assign trap_now  = s1_clash && (s1_pol == CLASH_TRAP || s1_pol == CLASH_RSVD);
  assign block_now = s1_clash && (s1_pol != CLASH_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      wr_en       <= 1'b0;
      undef_flag  <= 1'b0;
      unpred_flag <= 1'b0;
    end else begin
      out_valid   <= s1_valid;
      wr_en       <= s1_valid && !block_now;
      undef_flag  <= s1_valid && trap_now;
      unpred_flag <= s1_valid && (s1_resv || s1_clash);
    end
  end

  assign res_hi = s2_sum[ACC_W-1:WORD_W];
  assign res_lo = s2_sum[WORD_W-1:0];

  // cycles since reset, used to keep the latency check inside its history
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!wr_en && !undef_flag && !unpred_flag));

  assert_trap_blocks_write_R6: assert property (@(posedge clk) disable iff (rst)
    undef_flag |-> (!wr_en && unpred_flag));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !unpred_flag) |-> (wr_en && !undef_flag));
endmodule

// File: tb/test_dual_mac_unit.sv
module test_dual_mac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_hi = '0, acc_lo = '0;
  logic        swap = 1'b0;
  logic [3:0]  idx_dlo = 4'd0, idx_dhi = 4'd1, idx_a = 4'd2, idx_b = 4'd3;
  logic [1:0]  clash_policy = 2'd0;
  logic        out_valid, wr_en, undef_flag, unpred_flag;
  logic [31:0] res_hi, res_lo;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          v;
    logic [63:0] sum;
    bit          data_known;
    bit          wr;
    bit          und;
    bit          unp;
    string       tag;
  } exp_t;

  exp_t pipe[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mac_unit i_dual_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .swap(swap), .idx_dlo(idx_dlo),
    .idx_dhi(idx_dhi), .idx_a(idx_a), .idx_b(idx_b),
    .clash_policy(clash_policy), .out_valid(out_valid), .res_hi(res_hi),
    .res_lo(res_lo), .wr_en(wr_en), .undef_flag(undef_flag),
    .unpred_flag(unpred_flag)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_sum(logic [31:0] a, logic [31:0] b, bit sw,
                                          logic [31:0] hi, logic [31:0] lo);
    logic [31:0] bs;
    longint p0, p1, acc;
    bs  = sw ? {b[15:0], b[31:16]} : b;
    p0  = longint'($signed(a[15:0]))  * longint'($signed(bs[15:0]));
    p1  = longint'($signed(a[31:16])) * longint'($signed(bs[31:16]));
    acc = longint'({hi, lo});
    return 64'(p0 + p1 + acc);
  endfunction

  task automatic compare_front();
    exp_t e;
    if (pipe.size() < 2) return;
    e = pipe.pop_front();
    check("R7", "out_valid", 64'(out_valid), 64'(e.v));
    if (!e.v) begin
      check("R9", "quiet flags", {61'd0, wr_en, undef_flag, unpred_flag}, 64'd0);
      return;
    end
    check(e.tag, "wr_en", 64'(wr_en), 64'(e.wr));
    check(e.tag, "undef_flag", 64'(undef_flag), 64'(e.und));
    check(e.tag, "unpred_flag", 64'(unpred_flag), 64'(e.unp));
    if (e.data_known) begin
      check(e.tag, "res_hi", 64'(res_hi), 64'(e.sum[63:32]));
      check(e.tag, "res_lo", 64'(res_lo), 64'(e.sum[31:0]));
    end
  endtask

  task automatic issue(bit v, logic [31:0] a, logic [31:0] b, bit sw,
                       logic [31:0] hi, logic [31:0] lo,
                       logic [3:0] dlo, logic [3:0] dhi, logic [3:0] ia,
                       logic [3:0] ib, logic [1:0] pol, string tag);
    exp_t e;
    bit clash, resv;
    @(negedge clk);
    compare_front();
    in_valid = v; op_a = a; op_b = b; swap = sw; acc_hi = hi; acc_lo = lo;
    idx_dlo = dlo; idx_dhi = dhi; idx_a = ia; idx_b = ib; clash_policy = pol;
    clash = (dhi == dlo);
    resv  = (dlo == 4'd15) || (dhi == 4'd15) || (ia == 4'd15) || (ib == 4'd15);
    e.v   = v;
    e.sum = ref_sum(a, b, sw, hi, lo);
    e.data_known = !clash;
    e.unp = clash || resv;
    e.und = clash && (pol == 2'd0 || pol == 2'd3);
    e.wr  = !(clash && pol != 2'd2);
    e.tag = tag;
    pipe.push_back(e);
  endtask

  task automatic op(logic [31:0] a, logic [31:0] b, bit sw,
                    logic [31:0] hi, logic [31:0] lo, string tag);
    issue(1'b1, a, b, sw, hi, lo, 4'd0, 4'd1, 4'd2, 4'd3, 2'd0, tag);
  endtask

  task automatic idle();
    issue(1'b0, '0, '0, 1'b0, '0, '0, 4'd0, 4'd1, 4'd2, 4'd3, 2'd0, "R7");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check("R8", "reset outputs",
          {res_hi, res_lo}, 64'd0);
    check("R8", "reset flags",
          {60'd0, out_valid, wr_en, undef_flag, unpred_flag}, 64'd0);

    // R1 matching products, R4 word split
    op(32'h0003_0002, 32'h0005_0007, 1'b0, 32'h0, 32'h0, "R1");
    op(32'hFFFF_8000, 32'h7FFF_0001, 1'b0, 32'h0000_0001, 32'hFFFF_FFF0, "R1");
    op(32'h1234_ABCD, 32'hFEDC_0123, 1'b0, 32'h8000_0000, 32'h0000_0000, "R4");
    // R2 cross products
    op(32'h0003_0002, 32'h0005_0007, 1'b1, 32'h0, 32'h0, "R2");
    op(32'h8000_7FFF, 32'h0001_8000, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    // R10 corner
    op(32'h8000_8000, 32'h8000_8000, 1'b0, 32'h0, 32'h0, "R10");
    op(32'h8000_8000, 32'h8000_8000, 1'b1, 32'h0, 32'h0, "R10");
    idle();
    // R3 wrap at both signed limits
    op(32'h8000_8000, 32'h8000_8000, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3");
    op(32'h7FFF_7FFF, 32'h8000_8000, 1'b0, 32'h8000_0000, 32'h0000_0000, "R3");
    idle();
    idle();
    // R5 reserved index on each field
    issue(1'b1, 32'h11, 32'h22, 1'b0, 0, 5, 4'd15, 4'd1, 4'd2, 4'd3, 2'd0, "R5");
    issue(1'b1, 32'h11, 32'h22, 1'b0, 0, 5, 4'd0, 4'd15, 4'd2, 4'd3, 2'd0, "R5");
    issue(1'b1, 32'h11, 32'h22, 1'b0, 0, 5, 4'd0, 4'd1, 4'd15, 4'd3, 2'd0, "R5");
    issue(1'b1, 32'h11, 32'h22, 1'b0, 0, 5, 4'd0, 4'd1, 4'd2, 4'd15, 2'd0, "R5");
    // R6 each policy code with equal destinations
    for (int p = 0; p < 4; p++)
      issue(1'b1, 32'h33, 32'h44, 1'b0, 0, 1, 4'd6, 4'd6, 4'd2, 4'd3, 2'(p), "R6");
    // policy ignored without a clash
    issue(1'b1, 32'h33, 32'h44, 1'b0, 0, 1, 4'd6, 4'd7, 4'd2, 4'd3, 2'd1, "R6");
    // random traffic with gaps
    for (int i = 0; i < 400; i++) begin
      bit v = ($urandom_range(0, 3) != 0);
      logic [3:0] d0 = 4'($urandom_range(0, 15));
      logic [3:0] d1 = ($urandom_range(0, 7) == 0) ? d0 : 4'($urandom_range(0, 15));
      bit sw = 1'($urandom);
      issue(v, $urandom, $urandom, sw, $urandom, $urandom, d0, d1,
            4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
            2'($urandom_range(0, 3)), sw ? "R2" : "R1");
    end
    idle();
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule